// File: doc/BRIEF.md
# Split Read Tag Tracker

This block keeps the requester's records for a registered bus on which a target may answer a read with a split response. When the master issues a read, the tracker gives it the lowest-numbered free tag. It stores the start address and the byte count requested for that tag. Later the target sends a notice that it has split the read. After that the target returns the data as completion beats. Each beat carries a tag and a byte count.

Several split reads may be outstanding at once. Beats for different tags may interleave in any order. The tracker matches every beat to its tag and subtracts the bytes delivered. When a tag's count reaches zero it reports the tag and then returns it to the free pool.

The tracker also flags protocol errors. It raises an error when a beat stops short of the full count away from a 128-byte boundary. It raises a second kind of error when a beat or notice arrives that does not belong to any live read in the right state. The block only does this bookkeeping. Bus signalling and data storage are handled elsewhere.

Top module: `split_tag_tracker`

## Requirements
- R1: After reset all 32 tags are free, `req_ready` is 1 and `req_tag` is 0, and `done_valid`, `boundary_error` and `unexpected_completion` are 0.
- R2: While `req_ready` is 1, `req_tag` shows the lowest-numbered free tag (5-bit tag, 0 to 31). A cycle with `req_valid` high takes that tag and records `req_addr` and `req_count`.
- R3: When all 32 tags are held, `req_ready` is 0 and a raised `req_valid` takes no tag.
- R4: A split notice (`split_valid`, `split_tag`) moves an issued tag into the split state. Completion beats are accepted only for tags in that state.
- R5: A completion beat for a tag that is free or not yet split raises `unexpected_completion` for one cycle, starting in the cycle after the beat, and changes no state.
- R6: A completion beat whose byte count is 0 or larger than the bytes remaining raises `unexpected_completion` in the next cycle and leaves that tag's count and address unchanged.
- R7: An accepted beat subtracts its bytes from the tag's remaining count and advances the tag's address by the same amount. Beats for different tags may interleave freely.
- R8: The beat that brings a tag's count to zero causes `done_valid` to be 1 for exactly the next cycle, with `done_tag` equal to that tag.
- R9: A retired tag is still held during its `done_valid` cycle. It is free, and eligible for allocation, from the following cycle.
- R10: An accepted beat that leaves bytes remaining raises `boundary_error` in the next cycle if its end address (current address plus bytes) is not a multiple of 128. The beat is still applied. A final beat never raises it.
- R11: A split notice for a tag that is not in the issued state raises `unexpected_completion` in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read being issued this cycle |
| req_addr | input | 16 | Start byte address of the read |
| req_count | input | 12 | Byte count of the read, nonzero |
| req_ready | output | 1 | A free tag exists |
| req_tag | output | 5 | Tag given to the read |
| split_valid | input | 1 | Target reported a split response |
| split_tag | input | 5 | Tag of the read that was split |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | 5 | Tag carried by the beat |
| cpl_bytes | input | 12 | Bytes delivered by the beat |
| done_valid | output | 1 | A tag was fully delivered (pulse) |
| done_tag | output | 5 | Tag that was fully delivered |
| boundary_error | output | 1 | Partial beat ended off a 128-byte boundary |
| unexpected_completion | output | 1 | Beat or notice with no matching live read |

## Verification
The in-design checks assume that the requester never issues a read with a zero byte count, since such a tag could never retire. This assumption is stated as an input assertion. The bench keeps every request count nonzero.

Beats and notices that are illegal are sent on purpose to exercise R5, R6 and R11. The properties therefore do not assume legal completions. They only assume that illegal traffic leaves state unchanged.

All stimulus changes on the falling clock edge. As a result, each request, notice or beat is seen by exactly one rising edge.

// File: rtl/split_tag_pkg.sv
package split_tag_pkg;

  typedef enum logic [1:0] {
    TS_FREE   = 2'd0,
    TS_ISSUED = 2'd1,
    TS_SPLIT  = 2'd2,
    TS_RETIRE = 2'd3
  } tag_state_e;

  // Beat is usable only if it delivers something and no more than remains.
  function automatic logic beat_fits(input logic [31:0] remaining,
                                     input logic [31:0] bytes);
    return (bytes != 32'd0) && (bytes <= remaining);
  endfunction

  // End address of a beat lands on a 2**lg byte boundary.
  function automatic logic ends_aligned(input logic [31:0] addr,
                                        input logic [31:0] bytes,
                                        input int unsigned lg);
    logic [31:0] fin;
    logic [31:0] mask;
    fin  = addr + bytes;
    mask = (32'd1 << lg) - 32'd1;
    return (fin & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/tag_lowest_free.sv
module tag_lowest_free #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     free_vec,
  output logic             any_free,
  output logic [IDX_W-1:0] pick
);

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = IDX_W'(i);
    end
  end

  assign any_free = |free_vec;

  // R2: the offered tag really is free
  a_r2_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> free_vec[pick]);

endmodule

// File: rtl/tag_slot.sv
module tag_slot
  import split_tag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [CNT_W-1:0]  alloc_cnt,
  input  logic              split_en,
  input  logic              beat_en,
  input  logic [CNT_W-1:0]  beat_bytes,
  output tag_state_e        state,
  output logic [CNT_W-1:0]  remaining,
  output logic [ADDR_W-1:0] cur_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TS_FREE;
      remaining <= '0;
      cur_addr  <= '0;
    end else begin
      unique case (state)
        TS_FREE: if (alloc_en) begin
          state     <= TS_ISSUED;
          remaining <= alloc_cnt;
          cur_addr  <= alloc_addr;
        end
        TS_ISSUED: if (split_en) state <= TS_SPLIT;
        TS_SPLIT: if (beat_en) begin
          remaining <= remaining - beat_bytes;
          cur_addr  <= cur_addr + ADDR_W'(beat_bytes);
          if (beat_bytes == remaining) state <= TS_RETIRE;
        end
        TS_RETIRE: state <= TS_FREE;
        default:   state <= TS_FREE;
      endcase
    end
  end

  // R2: allocation lands only on a free slot
  a_r2_alloc_on_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> state == TS_FREE);
  // R4: beats are applied only once the read has been split
  a_r4_beat_after_split: assert property (@(posedge clk) disable iff (!rst_n)
    beat_en |-> state == TS_SPLIT);
  // R6: a split slot without an accepted beat keeps its count
  a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_SPLIT && !beat_en) |=> $stable(remaining));
  // R9: retirement lasts exactly one cycle
  a_r9_retire_once: assert property (@(posedge clk) disable iff (!rst_n)
    state == TS_RETIRE |=> state == TS_FREE);

endmodule

// File: rtl/split_tag_tracker.sv
module split_tag_tracker
  import split_tag_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int BND_LG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_ready,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              split_valid,
  input  logic [TAG_W-1:0]  split_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [CNT_W-1:0]  cpl_bytes,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              boundary_error,
  output logic              unexpected_completion
);

  localparam int NTAGS = 1 << TAG_W;

  tag_state_e        st     [NTAGS];
  logic [CNT_W-1:0]  rem_q  [NTAGS];
  logic [ADDR_W-1:0] addr_q [NTAGS];
  logic [NTAGS-1:0]  free_vec;
  logic [NTAGS-1:0]  alloc_en;
  logic [NTAGS-1:0]  split_en;
  logic [NTAGS-1:0]  beat_en;

  // Named internal events
  logic take_req;
  logic split_ok;
  logic cpl_ok;
  logic cpl_final;
  logic cpl_misaligned;

  tag_lowest_free #(.N(NTAGS), .IDX_W(TAG_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .free_vec (free_vec),
    .any_free (req_ready),
    .pick     (req_tag)
  );

  assign take_req = req_valid && req_ready;
  assign split_ok = st[split_tag] == TS_ISSUED;
  assign cpl_ok   = (st[cpl_tag] == TS_SPLIT) &&
                    beat_fits(32'(rem_q[cpl_tag]), 32'(cpl_bytes));
  assign cpl_final = cpl_bytes == rem_q[cpl_tag];
  assign cpl_misaligned = !ends_aligned(32'(addr_q[cpl_tag]), 32'(cpl_bytes), BND_LG);

  for (genvar g = 0; g < NTAGS; g++) begin : g_slot
    assign free_vec[g] = st[g] == TS_FREE;
    assign alloc_en[g] = take_req && (req_tag == TAG_W'(g));
    assign split_en[g] = split_valid && split_ok && (split_tag == TAG_W'(g));
    assign beat_en[g]  = cpl_valid && cpl_ok && (cpl_tag == TAG_W'(g));

    tag_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_en[g]),
      .alloc_addr (req_addr),
      .alloc_cnt  (req_count),
      .split_en   (split_en[g]),
      .beat_en    (beat_en[g]),
      .beat_bytes (cpl_bytes),
      .state      (st[g]),
      .remaining  (rem_q[g]),
      .cur_addr   (addr_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid            <= 1'b0;
      done_tag              <= '0;
      boundary_error        <= 1'b0;
      unexpected_completion <= 1'b0;
    end else begin
      done_valid            <= cpl_valid && cpl_ok && cpl_final;
      done_tag              <= cpl_tag;
      boundary_error        <= cpl_valid && cpl_ok && !cpl_final && cpl_misaligned;
      unexpected_completion <= (cpl_valid && !cpl_ok) || (split_valid && !split_ok);
    end
  end

  // R2: input rule - a read never asks for zero bytes
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_count != '0);
  // R3: no tag is taken while every tag is held
  a_r3_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> alloc_en == '0);
  // R8: the reported tag is the one in its retire cycle
  a_r8_done_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> st[done_tag] == TS_RETIRE);
  // R10: a final beat never reports a boundary fault
  a_r10_not_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    !(boundary_error && done_valid));
  // R5: an illegal beat touches no slot
  a_r5_illegal_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ok) |-> $countones(beat_en) == 0);

endmodule

// File: tb/split_tag_tracker_tb.sv
`timescale 1ns/1ps
module split_tag_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [11:0] req_count = '0;
  logic        req_ready;
  logic [4:0]  req_tag;
  logic        split_valid = 1'b0;
  logic [4:0]  split_tag = '0;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_tag = '0;
  logic [11:0] cpl_bytes = '0;
  logic        done_valid;
  logic [4:0]  done_tag;
  logic        boundary_error;
  logic        unexpected_completion;

  int checks = 0;
  int errors = 0;
  int got_tag;
  logic o_done, o_bnd, o_unx;
  int o_dtag;

  always #4 clk = ~clk;

  split_tag_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_count(req_count),
    .req_ready(req_ready), .req_tag(req_tag),
    .split_valid(split_valid), .split_tag(split_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
    .done_valid(done_valid), .done_tag(done_tag),
    .boundary_error(boundary_error), .unexpected_completion(unexpected_completion)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input int addr, input int cnt);
    req_valid = 1'b1; req_addr = addr[15:0]; req_count = cnt[11:0];
    #1 got_tag = int'(req_tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic notice(input int tag);
    split_valid = 1'b1; split_tag = tag[4:0];
    @(negedge clk);
    o_unx = unexpected_completion;
    split_valid = 1'b0;
  endtask

  task automatic beat(input int tag, input int bytes);
    cpl_valid = 1'b1; cpl_tag = tag[4:0]; cpl_bytes = bytes[11:0];
    @(negedge clk);
    o_done = done_valid; o_dtag = int'(done_tag);
    o_bnd = boundary_error; o_unx = unexpected_completion;
    cpl_valid = 1'b0;
  endtask

  // Table: start address, count, first beat, expected boundary fault, expected done
  localparam int NV = 8;
  localparam int V_ADDR [NV] = '{0,   0,   64,  64, 16,  127, 128, 0};
  localparam int V_CNT  [NV] = '{256, 256, 200, 64, 300, 10,  129, 50};
  localparam int V_BEAT [NV] = '{128, 100, 64,  64, 300, 1,   128, 49};
  localparam int V_BND  [NV] = '{0,   1,   0,   0,  0,   0,   0,   1};
  localparam int V_DONE [NV] = '{0,   0,   0,   1,  1,   0,   0,   0};

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 tag", int'(req_tag), 0);
    chk("R1 done", int'(done_valid), 0);
    chk("R1 flags", int'(boundary_error) + int'(unexpected_completion), 0);

    // R2 lowest-free allocation
    issue(0, 256);     chk("R2 first tag", got_tag, 0);
    issue(256, 128);   chk("R2 second tag", got_tag, 1);
    issue(512, 384);   chk("R2 third tag", got_tag, 2);

    // R5 beats to issued-but-not-split and to free tags
    beat(1, 128); chk("R5 not split", int'(o_unx), 1); chk("R5 no done", int'(o_done), 0);
    beat(5, 16);  chk("R5 free tag", int'(o_unx), 1);
    // R11 split notice to a free tag
    notice(7);    chk("R11 notice free", int'(o_unx), 1);
    // R4 legal notices
    notice(0);    chk("R4 notice 0", int'(o_unx), 0);
    notice(1);    chk("R4 notice 1", int'(o_unx), 0);
    notice(2);    chk("R4 notice 2", int'(o_unx), 0);
    notice(2);    chk("R11 notice twice", int'(o_unx), 1);

    // R6 over-long and empty beats
    beat(0, 300); chk("R6 too long", int'(o_unx), 1); chk("R6 no done", int'(o_done), 0);
    beat(0, 0);   chk("R6 zero bytes", int'(o_unx), 1);

    // R7 interleaved completions
    beat(2, 128); chk("R7 t2 part", int'(o_done) + int'(o_unx) + int'(o_bnd), 0);
    beat(0, 128); chk("R7 t0 part", int'(o_done) + int'(o_unx) + int'(o_bnd), 0);
    beat(1, 128); chk("R8 t1 done", int'(o_done), 1); chk("R8 t1 tag", o_dtag, 1);
    beat(2, 128); chk("R7 t2 part2", int'(o_done), 0);
    beat(0, 128); chk("R8 t0 done", int'(o_done), 1); chk("R8 t0 tag", o_dtag, 0);
    beat(2, 128); chk("R8 t2 done", int'(o_done), 1); chk("R8 t2 tag", o_dtag, 2);
    @(negedge clk);
    chk("R8 pulse ends", int'(done_valid), 0);
    chk("R9 all free tag", int'(req_tag), 0);

    // Table of boundary cases on tag 0
    for (int v = 0; v < NV; v++) begin
      issue(V_ADDR[v], V_CNT[v]);
      chk("R2 table tag", got_tag, 0);
      notice(0);
      beat(0, V_BEAT[v]);
      chk("R10 table fault", int'(o_bnd), V_BND[v]);
      chk("R8 table done", int'(o_done), V_DONE[v]);
      if (V_DONE[v] == 0) begin
        beat(0, V_CNT[v] - V_BEAT[v]);
        chk("R10 final no fault", int'(o_bnd), 0);
        chk("R7 table finish", int'(o_done), 1);
      end
      @(negedge clk);
    end

    // R3 all tags held
    for (int i = 0; i < 32; i++) begin
      issue(i * 256, 128);
      chk("R2 fill tag", got_tag, i);
    end
    chk("R3 full ready", int'(req_ready), 0);
    req_valid = 1'b1; req_addr = 16'h0; req_count = 12'd4;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 still full", int'(req_ready), 0);
    notice(9);     chk("R4 notice 9", int'(o_unx), 0);
    beat(9, 128);  chk("R8 t9 done", int'(o_done), 1); chk("R8 t9 tag", o_dtag, 9);
    chk("R9 held in done cycle", int'(req_ready), 0);
    @(negedge clk);
    chk("R9 freed ready", int'(req_ready), 1);
    chk("R9 freed tag", int'(req_tag), 9);
    issue(0, 64);  chk("R9 reuse tag", got_tag, 9);
    chk("R3 full again", int'(req_ready), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule